// File: doc/BRIEF.md
# Reconfigurable Region Swap Sequencer

This controller takes one reconfigurable logic region through a safe exchange of its contents. A host asks for a swap with `swapReq`. The controller accepts the request only when the device reports that it is in normal operating mode and no swap is already running.

Once a request is accepted, the steps run in a fixed order:

1. The region is asked to drain its work, and the controller waits for the region to acknowledge.
2. The region's outputs are frozen and the clock enables of its pre-loaded memories are gated off.
3. An external transfer engine is started and the controller waits for it to report done or error.
4. If the transfer succeeds, the region is held in reset for a fixed number of cycles.
5. The freeze is lifted and the region is asked to start. The controller waits for the start acknowledge.

A failed transfer, or an acknowledge that never arrives, leaves the region frozen and sets a sticky error flag. The host follows progress through `busy`, a one-cycle `done` pulse and `error`. The controller does not move the configuration data itself, and it does not contain the per-bus freeze bridges.

Top module: `rr_swap_ctrl`

## Requirements
- R1: A request is accepted only when `devReady` is high and `busy` is low. On acceptance, `busy` and `stopReq` are high from the next cycle on. A request while `devReady` is low leaves every output unchanged.
- R2: `stopReq` stays high until `stopAck` is sampled high. It is low in the following cycle. With an acknowledge delay of d cycles, `stopReq` is high for d+1 cycles.
- R3: In the cycle after `stopAck` is sampled, `freeze` is high and `memClkEn` is low, and this holds before any transfer starts.
- R4: `xferStart` is a single-cycle pulse that is issued exactly once per swap that gets past the stop handshake. It is issued only while `freeze` is high and `memClkEn` is low.
- R5: `regionRst` is high for exactly RST_CYCLES consecutive cycles (default 4), and only after `xferDone`. While it is high, `freeze` stays high and `memClkEn` stays low.
- R6: On the edge that ends the reset pulse, `freeze` falls, `memClkEn` rises and `startReq` rises together. `startReq` is never high while `freeze` is high.
- R7: `startReq` stays high until `startAck` is sampled. In the next cycle the controller is idle and `done` is high for exactly one cycle.
- R8: If `xferErr` is sampled during the transfer wait, the controller returns to idle with no reset pulse and no `done`. `freeze` stays high, `memClkEn` stays low and `error` is set. `xferErr` takes priority over `xferDone`.
- R9: If either acknowledge does not arrive within ACK_TIMEOUT cycles (default 32) of its request rising, the request drops and the controller returns to idle. `error` is set, `freeze` is high and `memClkEn` is low.
- R10: `busy` is high from acceptance until the return to idle. A `swapReq` held high during a swap starts no second sequence: exactly one `xferStart` is issued for that swap.
- R11: `error` stays set through later successful swaps and is cleared only by reset. After reset, `busy`, `done`, `error`, `stopReq`, `startReq`, `freeze`, `regionRst` and `xferStart` are low and `memClkEn` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| devReady | input | 1 | Device is in normal operating mode |
| swapReq | input | 1 | Host request to swap the region |
| busy | output | 1 | A swap is in progress |
| done | output | 1 | One-cycle pulse when a swap finishes cleanly |
| error | output | 1 | Sticky failure flag |
| stopReq | output | 1 | Asks the region to drain and stop |
| stopAck | input | 1 | Region has drained |
| freeze | output | 1 | Freezes the region outputs |
| memClkEn | output | 1 | Clock enable for the region's pre-loaded memories (low = gated) |
| regionRst | output | 1 | Reset to the region |
| startReq | output | 1 | Asks the region to begin operation |
| startAck | input | 1 | Region has started |
| xferStart | output | 1 | One-cycle start pulse to the transfer engine |
| xferDone | input | 1 | Transfer engine finished cleanly |
| xferErr | input | 1 | Transfer engine failed |

## Verification
Two decisions can fall on the same edge.

The first pair is the end of the reset pulse and the release of freeze with the start request. The bench samples every cycle. It checks that no reset cycle appears with the memory enable open, and that no start-request cycle appears while the region is frozen.

The second pair is a held host request and the sequencer's return to idle. The bench keeps `swapReq` high through a whole swap. It judges the result by the count of transfer-start pulses, which must be exactly one. Transfer done and error are also driven in the same cycle, so that the error path is shown to take priority.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_STOP,
    S_KICK,
    S_XFER,
    S_RST,
    S_START
  } seqState_t;

  typedef struct packed {
    logic freezeOn;
    logic freezeOff;
    logic gateOn;
    logic gateOff;
    logic kick;
    logic rstLoad;
    logic tmrRun;
    logic setErr;
    logic finish;
  } seqStrobes_t;

endpackage

// File: rtl/rrs_datapath.sv
module rrs_datapath
  import rrs_pkg::*;
#(
  parameter int RST_CYCLES  = 4,
  parameter int ACK_TIMEOUT = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  seqStrobes_t stb,
  output logic        rstLast,
  output logic        timeout,
  output logic        freeze,
  output logic        memClkEn,
  output logic        regionRst,
  output logic        xferStart,
  output logic        done,
  output logic        error
);
  localparam int RW = $clog2(RST_CYCLES + 1);
  localparam int TW = $clog2(ACK_TIMEOUT + 1);
  localparam logic [RW-1:0] RST_LOAD = RW'(RST_CYCLES);
  localparam logic [TW-1:0] TMR_LAST = TW'(ACK_TIMEOUT - 1);

  logic [RW-1:0] rstCnt;
  logic [TW-1:0] tmr;
  logic          freezeQ, gateQ, kickQ, doneQ, errQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freezeQ <= 1'b0;
      gateQ   <= 1'b0;
      kickQ   <= 1'b0;
      doneQ   <= 1'b0;
      errQ    <= 1'b0;
      rstCnt  <= '0;
      tmr     <= '0;
    end else begin
      if (stb.freezeOn)       freezeQ <= 1'b1;
      else if (stb.freezeOff) freezeQ <= 1'b0;
      if (stb.gateOn)         gateQ   <= 1'b1;
      else if (stb.gateOff)   gateQ   <= 1'b0;
      kickQ <= stb.kick;
      doneQ <= stb.finish;
      if (stb.setErr)         errQ    <= 1'b1;
      if (stb.rstLoad)        rstCnt  <= RST_LOAD;
      else if (rstCnt != '0)  rstCnt  <= rstCnt - 1'b1;
      if (!stb.tmrRun)        tmr     <= '0;
      else if (tmr != TMR_LAST) tmr   <= tmr + 1'b1;
    end
  end

  assign rstLast   = (rstCnt == RW'(1));
  assign timeout   = (tmr == TMR_LAST);
  assign freeze    = freezeQ;
  assign memClkEn  = ~gateQ;
  assign regionRst = (rstCnt != '0);
  assign xferStart = kickQ;
  assign done      = doneQ;
  assign error     = errQ;

  p_xfer_frozen_r4: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |-> (freeze && !memClkEn));
  p_xfer_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |=> !xferStart);
  p_rst_gated_r5: assert property (@(posedge clk) disable iff (!rstN)
    regionRst |-> (freeze && !memClkEn));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    error |=> error);
endmodule

// File: rtl/rrs_ctrl.sv
module rrs_ctrl
  import rrs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        devReady,
  input  logic        swapReq,
  input  logic        stopAck,
  input  logic        startAck,
  input  logic        xferDone,
  input  logic        xferErr,
  input  logic        rstLast,
  input  logic        timeout,
  output seqStrobes_t stb,
  output logic        stopReq,
  output logic        startReq,
  output logic        busy
);
  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb       = '0;
    nextState = state;
    unique case (state)
      S_IDLE:  if (swapReq && devReady) nextState = S_STOP;
      S_STOP: begin
        if (stopAck) begin
          stb.freezeOn = 1'b1;
          stb.gateOn   = 1'b1;
          nextState    = S_KICK;
        end else if (timeout) begin
          stb.setErr   = 1'b1;
          stb.freezeOn = 1'b1;
          stb.gateOn   = 1'b1;
          nextState    = S_IDLE;
        end else begin
          stb.tmrRun = 1'b1;
        end
      end
      S_KICK: begin
        stb.kick  = 1'b1;
        nextState = S_XFER;
      end
      S_XFER: begin
        if (xferErr) begin
          stb.setErr = 1'b1;
          nextState  = S_IDLE;
        end else if (xferDone) begin
          stb.rstLoad = 1'b1;
          nextState   = S_RST;
        end
      end
      S_RST: begin
        if (rstLast) begin
          stb.freezeOff = 1'b1;
          stb.gateOff   = 1'b1;
          nextState     = S_START;
        end
      end
      S_START: begin
        if (startAck) begin
          stb.finish = 1'b1;
          nextState  = S_IDLE;
        end else if (timeout) begin
          stb.setErr   = 1'b1;
          stb.freezeOn = 1'b1;
          stb.gateOn   = 1'b1;
          nextState    = S_IDLE;
        end else begin
          stb.tmrRun = 1'b1;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign stopReq  = (state == S_STOP);
  assign startReq = (state == S_START);
  assign busy     = (state != S_IDLE);

  p_reject_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && swapReq && !devReady) |=> !busy);
  p_accept_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && swapReq && devReady) |=> (busy && stopReq));
  p_stop_drop_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stopReq && stopAck) |=> !stopReq);
  p_start_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && startAck) |=> (!startReq && !busy));
endmodule

// File: rtl/rr_swap_ctrl.sv
module rr_swap_ctrl
  import rrs_pkg::*;
#(
  parameter int RST_CYCLES  = 4,
  parameter int ACK_TIMEOUT = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic devReady,
  input  logic swapReq,
  output logic busy,
  output logic done,
  output logic error,
  output logic stopReq,
  input  logic stopAck,
  output logic freeze,
  output logic memClkEn,
  output logic regionRst,
  output logic startReq,
  input  logic startAck,
  output logic xferStart,
  input  logic xferDone,
  input  logic xferErr
);
  seqStrobes_t stb;
  logic        rstLast, timeout;

  rrs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .devReady(devReady), .swapReq(swapReq),
    .stopAck(stopAck), .startAck(startAck), .xferDone(xferDone),
    .xferErr(xferErr), .rstLast(rstLast), .timeout(timeout), .stb(stb),
    .stopReq(stopReq), .startReq(startReq), .busy(busy)
  );

  rrs_datapath #(.RST_CYCLES(RST_CYCLES), .ACK_TIMEOUT(ACK_TIMEOUT)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rstLast(rstLast), .timeout(timeout),
    .freeze(freeze), .memClkEn(memClkEn), .regionRst(regionRst),
    .xferStart(xferStart), .done(done), .error(error)
  );

  p_start_unfrozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    startReq |-> (!freeze && memClkEn));
endmodule

// File: tb/sim_rr_swap_ctrl.sv
module sim_rr_swap_ctrl;
  localparam int RSTC = 4;
  localparam int TO   = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic devReady = 1'b0, swapReq = 1'b0, stopAck = 1'b0, startAck = 1'b0;
  logic xferDone = 1'b0, xferErr = 1'b0;
  logic busy, done, error, stopReq, freeze, memClkEn, regionRst, startReq, xferStart;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  rr_swap_ctrl #(.RST_CYCLES(RSTC), .ACK_TIMEOUT(TO)) u0 (
    .clk(clk), .rstN(rstN), .devReady(devReady), .swapReq(swapReq),
    .busy(busy), .done(done), .error(error), .stopReq(stopReq),
    .stopAck(stopAck), .freeze(freeze), .memClkEn(memClkEn),
    .regionRst(regionRst), .startReq(startReq), .startAck(startAck),
    .xferStart(xferStart), .xferDone(xferDone), .xferErr(xferErr)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: act=%0d exp<150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    int   sDly;
    int   aDly;
    logic err;
    logic both;
    logic hold;
    logic expDone;
    logic expErr;
    logic expFreeze;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{sDly: 0,  aDly: 0,  err: 1'b0, both: 1'b0, hold: 1'b0, expDone: 1'b1, expErr: 1'b0, expFreeze: 1'b0},
    '{sDly: 3,  aDly: 5,  err: 1'b0, both: 1'b0, hold: 1'b1, expDone: 1'b1, expErr: 1'b0, expFreeze: 1'b0},
    '{sDly: 2,  aDly: 0,  err: 1'b1, both: 1'b0, hold: 1'b0, expDone: 1'b0, expErr: 1'b1, expFreeze: 1'b1},
    '{sDly: 0,  aDly: 1,  err: 1'b0, both: 1'b0, hold: 1'b0, expDone: 1'b1, expErr: 1'b1, expFreeze: 1'b0},
    '{sDly: 40, aDly: 0,  err: 1'b0, both: 1'b0, hold: 1'b0, expDone: 1'b0, expErr: 1'b1, expFreeze: 1'b1},
    '{sDly: 1,  aDly: 40, err: 1'b0, both: 1'b0, hold: 1'b0, expDone: 1'b0, expErr: 1'b1, expFreeze: 1'b1},
    '{sDly: 0,  aDly: 0,  err: 1'b1, both: 1'b1, hold: 1'b0, expDone: 1'b0, expErr: 1'b1, expFreeze: 1'b1}
  };

  task automatic runVec(input vec_t v);
    int sc = 0, ac = 0, xw = 0, rstLen = 0, xferCnt = 0;
    bit gotDone = 0, orderBad = 0, gateBad = 0, startBad = 0;
    int expRst;
    @(negedge clk);
    devReady = 1'b1;
    swapReq  = 1'b1;
    @(negedge clk);
    if (!v.hold) swapReq = 1'b0;
    chk("R1 busy after accept", int'(busy), 1);
    chk("R1 stopReq after accept", int'(stopReq), 1);
    for (int cyc = 0; cyc < 400; cyc++) begin
      stopAck  = stopReq && (sc >= v.sDly);
      if (stopReq) sc++;
      startAck = startReq && (ac >= v.aDly);
      if (startReq) ac++;
      xferDone = 1'b0;
      xferErr  = 1'b0;
      if (xferStart) begin
        xferCnt++;
        if (!freeze || memClkEn) orderBad = 1;
        xw = 3;
      end else if (xw > 0) begin
        xw--;
        if (xw == 0) begin
          xferErr  = v.err;
          xferDone = !v.err || v.both;
        end
      end
      if (regionRst) begin
        rstLen++;
        if (memClkEn || !freeze) gateBad = 1;
      end
      if (startReq && (freeze || !memClkEn)) startBad = 1;
      if (done) gotDone = 1;
      if (!busy) break;
      @(negedge clk);
    end
    swapReq = 1'b0; stopAck = 1'b0; startAck = 1'b0;
    xferDone = 1'b0; xferErr = 1'b0;
    expRst = (!v.err && v.sDly < TO) ? RSTC : 0;
    chk("R2/R9 stopReq length", sc, (v.sDly >= TO) ? TO : v.sDly + 1);
    chk("R3/R4 transfer only while frozen and gated", int'(orderBad), 0);
    chk("R4/R10 single xferStart", xferCnt, (v.sDly < TO) ? 1 : 0);
    chk("R5 reset pulse length", rstLen, expRst);
    chk("R5 gated during reset", int'(gateBad), 0);
    chk("R6 startReq only unfrozen", int'(startBad), 0);
    if (expRst != 0)
      chk("R7/R9 startReq length", ac, (v.aDly >= TO) ? TO : v.aDly + 1);
    chk("R7 done pulse", int'(gotDone), int'(v.expDone));
    chk("R8/R9/R11 error flag", int'(error), int'(v.expErr));
    chk("R8/R9 freeze after", int'(freeze), int'(v.expFreeze));
    chk("R8/R9 memClkEn after", int'(memClkEn), int'(!v.expFreeze));
    @(negedge clk);
    chk("R7 done one cycle", int'(done), 0);
    chk("R10 idle after", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 reset busy", int'(busy), 0);
    chk("R11 reset error", int'(error), 0);
    chk("R11 reset freeze", int'(freeze), 0);
    chk("R11 reset memClkEn", int'(memClkEn), 1);
    chk("R11 reset outputs", int'({stopReq, startReq, regionRst, xferStart, done}), 0);

    for (int i = 0; i < 7; i++) runVec(VECS[i]);

    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 error cleared by reset", int'(error), 0);
    devReady = 1'b0;
    swapReq  = 1'b1;
    repeat (3) @(negedge clk);
    swapReq = 1'b0;
    chk("R1 not-ready busy", int'(busy), 0);
    chk("R1 not-ready stopReq", int'(stopReq), 0);
    chk("R1 not-ready freeze", int'(freeze), 0);
    @(negedge clk);
    chk("R1 not-ready still idle", int'(busy), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule